// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block is the digital controller placed between a processor-visible configuration byte and an eight-input successive-approximation converter core. Software writes one configuration register that chooses a channel, a clock divide, single-channel or scan operation, power, one-shot or repeating operation, and a run bit. The sequencer then issues one-cycle start strobes with a channel number to the converter core. It waits for each done pulse and files every returned 8-bit result into a per-channel result register, which software reads through a channel-indexed read port.

The three-bit channel field has two meanings. In single-channel operation it names the only channel converted. In scan operation it names the highest channel of an ascending scan that always begins at channel 0. After power is raised, a settling counter must expire before any converter start is issued. A start requested before then is held pending. An external halt input forces power off, which aborts all converter activity.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the configuration register reads 0, every result register reads 0, `busy`, `conv_start` and `conv_clk_en` are low.
- R2: The configuration byte has the channel field in bits 7:5, clock divide in bit 4, scan select in bit 3, power in bit 2, repeat (loop) in bit 1 and run in bit 0; a written value reads back unchanged on `cfg_rdata` unless hardware alters it as R5 or R10 state.
- R3: With scan select 0, only the channel named by the channel field is converted.
- R4: With scan select 1, channels 0 through the channel field are converted in ascending order; a field of 0 converts only channel 0.
- R5: With loop 0, setting run performs exactly one sequence, after which hardware clears the run bit (bit 0) and no further start is issued.
- R6: With loop 1, the sequence repeats without end while the run bit stays 1.
- R7: Writing run 0 during a sequence lets the conversion in flight finish and store its result, then the block goes idle with no further start.
- R8: At each accepted done pulse, the result register of the channel being converted is overwritten with `conv_result`; `rd_data` shows the register selected by `rd_sel`.
- R9: No converter start is issued until SETTLE_CYC cycles have passed with power held at 1; an earlier run request stays pending and is served afterwards.
- R10: While `halt` is 1, the power bit is forced to 0 (also against a write), activity stops at once, and a done pulse arriving after the abort is ignored.
- R11: `conv_clk_en` is 0 with power off, constantly 1 with power on and divide 0, and alternates every cycle with power on and divide 1.
- R12: Each start strobe lasts one cycle and the next strobe waits for a done pulse; `busy` is high from the first strobe until the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write value |
| cfg_rdata | output | 8 | Current configuration register |
| halt | input | 1 | Core halt state; forces power off |
| rd_sel | input | 3 | Result register select |
| rd_data | output | 8 | Selected result register |
| conv_start | output | 1 | One-cycle start strobe to the converter |
| conv_chan | output | 3 | Channel select to the converter |
| conv_clk_en | output | 1 | Converter clock enable |
| conv_done | input | 1 | Converter done pulse |
| conv_result | input | 8 | Converter result, valid with done |
| busy | output | 1 | Sequence in progress |

## Verification
A wrong channel counter or a wrong scan bound shows up as a mismatched `conv_chan` on the very next start strobe. The bench compares each strobe against an expected channel queue, so the error is caught at that strobe. A stale state after a stop or a halt appears as an unexpected extra strobe within a few cycles. A misrouted result write is caught when the result registers are read back after the sequence. A premature settle-counter expiry shows up as a strobe, or `busy`, before SETTLE_CYC cycles have elapsed. The run bit and the forced power bit are read back on `cfg_rdata` on the cycle after the event that changes them.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE   = 2'd0,
      SQ_LAUNCH = 2'd1,
      SQ_WAIT   = 2'd2
   } seq_state_e;

   // bit positions of the control fields, low end of the config byte
   localparam int unsigned CF_START    = 0;
   localparam int unsigned CF_LOOP     = 1;
   localparam int unsigned CF_POWER    = 2;
   localparam int unsigned CF_SEQ      = 3;
   localparam int unsigned CF_DIV      = 4;
   localparam int unsigned CF_CHAN_LSB = 5;
endpackage

// File: rtl/adc_cfg_reg.sv
module adc_cfg_reg
   import adc_scan_pkg::*;
#(
   parameter int unsigned CH_W = 3,
   localparam int unsigned CFG_W = CH_W + CF_CHAN_LSB
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CFG_W-1:0] wr_data,
   input  logic             halt,
   input  logic             run_clr,
   output logic [CFG_W-1:0] cfg_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else begin
         if (wr_en)
            cfg_q <= wr_data;
         else if (run_clr)
            cfg_q[CF_START] <= 1'b0;
         if (halt)
            cfg_q[CF_POWER] <= 1'b0;
      end
   end

   // R10
   halt_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> !cfg_q[CF_POWER]);
   // R5
   run_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_clr && !wr_en) |=> !cfg_q[CF_START]);
   // R2
   write_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !halt) |=> cfg_q == $past(wr_data));
endmodule

// File: rtl/adc_settle_timer.sv
module adc_settle_timer #(
   parameter int unsigned SETTLE_CYC = 6000,
   localparam int unsigned CNT_W = $clog2(SETTLE_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic power,
   output logic ready
);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SETTLE_CYC);

   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("adc_settle_timer: SETTLE_CYC must be at least 1");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !power)
         cnt <= '0;
      else if (cnt != LIMIT)
         cnt <= cnt + 1'b1;
   end

   assign ready = power && (cnt == LIMIT);

   // R9
   settle_not_instant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(power) |-> !ready);
endmodule

// File: rtl/adc_clk_gate.sv
module adc_clk_gate #(
   parameter bit HAS_DIV = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic power,
   input  logic div,
   output logic clk_en
);
   if (HAS_DIV) begin : g_div
      logic phase;
      always_ff @(posedge clk) begin
         if (!rst_n)
            phase <= 1'b0;
         else
            phase <= (power && div) ? ~phase : 1'b0;
      end
      assign clk_en = power && (!div || phase);

      // R11
      half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (power && div && $past(power && div)) |-> clk_en != $past(clk_en));
   end else begin : g_nodiv
      logic unused_div;
      assign unused_div = div;
      assign clk_en = power;
   end

   // R11
   off_no_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !power |-> !clk_en);
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CH_W   = 3,
   localparam int unsigned NUM_CH = 1 << CH_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CH_W-1:0]   wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [CH_W-1:0]   rd_sel,
   output logic [DATA_W-1:0] rd_data
);
   if (DATA_W < 1) begin : g_bad_width
      $error("adc_result_bank: DATA_W must be at least 1");
   end

   logic [DATA_W-1:0] rd_arr [NUM_CH];

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ent
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= '0;
         else if (wr_en && (wr_sel == CH_W'(i)))
            q <= wr_data;
      end
      assign rd_arr[i] = q;

      // R8
      entry_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_sel == CH_W'(i)) |=> q == $past(wr_data));
   end

   assign rd_data = rd_arr[rd_sel];
endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
   import adc_scan_pkg::*;
#(
   parameter int unsigned CH_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            power,
   input  logic            ready,
   input  logic            run_bit,
   input  logic            loop_bit,
   input  logic            scan_bit,
   input  logic [CH_W-1:0] field,
   input  logic            conv_done,
   output logic            conv_start,
   output logic [CH_W-1:0] conv_chan,
   output logic            res_we,
   output logic            run_clr,
   output logic            busy
);
   seq_state_e      state;
   logic [CH_W-1:0] chan;
   logic            at_last;
   logic [CH_W-1:0] first_chan;

   assign at_last    = scan_bit ? (chan >= field) : 1'b1;
   assign first_chan = scan_bit ? '0 : field;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SQ_IDLE;
         chan  <= '0;
      end else if (!power) begin
         state <= SQ_IDLE;
      end else begin
         unique case (state)
            SQ_IDLE: begin
               if (ready && run_bit) begin
                  state <= SQ_LAUNCH;
                  chan  <= first_chan;
               end
            end
            SQ_LAUNCH: state <= SQ_WAIT;
            SQ_WAIT: begin
               if (conv_done) begin
                  if (!run_bit) begin
                     state <= SQ_IDLE;
                  end else if (at_last) begin
                     if (loop_bit) begin
                        state <= SQ_LAUNCH;
                        chan  <= first_chan;
                     end else begin
                        state <= SQ_IDLE;
                     end
                  end else begin
                     state <= SQ_LAUNCH;
                     chan  <= chan + 1'b1;
                  end
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assign conv_start = power && (state == SQ_LAUNCH);
   assign busy       = power && (state != SQ_IDLE);
   assign conv_chan  = chan;
   assign res_we     = power && (state == SQ_WAIT) && conv_done;
   assign run_clr    = res_we && run_bit && at_last && !loop_bit;

   // R12
   start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);
   // R9
   start_after_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> ready);
   // R7
   stop_goes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_we && !run_bit) |=> !busy);
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
   import adc_scan_pkg::*;
#(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned CH_W       = 3,
   parameter int unsigned SETTLE_CYC = 6000,
   parameter bit          HAS_DIV    = 1'b1,
   localparam int unsigned CFG_W     = CH_W + CF_CHAN_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [CFG_W-1:0]  cfg_rdata,
   input  logic              halt,
   input  logic [CH_W-1:0]   rd_sel,
   output logic [DATA_W-1:0] rd_data,
   output logic              conv_start,
   output logic [CH_W-1:0]   conv_chan,
   output logic              conv_clk_en,
   input  logic              conv_done,
   input  logic [DATA_W-1:0] conv_result,
   output logic              busy
);
   if (CH_W < 1 || CH_W > 6) begin : g_bad_ch
      $error("adc_scan_seq: CH_W out of range");
   end

   logic [CFG_W-1:0] cfg_q;
   logic             run_clr;
   logic             settle_ready;
   logic             res_we;

   adc_cfg_reg #(.CH_W(CH_W)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_data (cfg_wdata),
      .halt    (halt),
      .run_clr (run_clr),
      .cfg_q   (cfg_q)
   );

   adc_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
      .clk   (clk),
      .rst_n (rst_n),
      .power (cfg_q[CF_POWER]),
      .ready (settle_ready)
   );

   adc_clk_gate #(.HAS_DIV(HAS_DIV)) u_clk (
      .clk    (clk),
      .rst_n  (rst_n),
      .power  (cfg_q[CF_POWER]),
      .div    (cfg_q[CF_DIV]),
      .clk_en (conv_clk_en)
   );

   adc_scan_fsm #(.CH_W(CH_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .power      (cfg_q[CF_POWER]),
      .ready      (settle_ready),
      .run_bit    (cfg_q[CF_START]),
      .loop_bit   (cfg_q[CF_LOOP]),
      .scan_bit   (cfg_q[CF_SEQ]),
      .field      (cfg_q[CFG_W-1:CF_CHAN_LSB]),
      .conv_done  (conv_done),
      .conv_start (conv_start),
      .conv_chan  (conv_chan),
      .res_we     (res_we),
      .run_clr    (run_clr),
      .busy       (busy)
   );

   adc_result_bank #(.DATA_W(DATA_W), .CH_W(CH_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (res_we),
      .wr_sel  (conv_chan),
      .wr_data (conv_result),
      .rd_sel  (rd_sel),
      .rd_data (rd_data)
   );

   assign cfg_rdata = cfg_q;
endmodule

// File: tb/adc_scan_seq_test.sv
module adc_scan_seq_test;
   localparam int S   = 6000;
   localparam int LAT = 3;

   logic       clk = 0;
   logic       rst_n = 0;
   logic       cfg_we = 0;
   logic [7:0] cfg_wdata = 0;
   logic [7:0] cfg_rdata;
   logic       halt = 0;
   logic [2:0] rd_sel = 0;
   logic [7:0] rd_data;
   logic       conv_start;
   logic [2:0] conv_chan;
   logic       conv_clk_en;
   logic       conv_done = 0;
   logic [7:0] conv_result = 0;
   logic       busy;

   int errs = 0, checks = 0;
   int exp_q[$];
   int n_starts = 0;
   int nres = 0;
   bit accept = 1;
   bit finished = 0;
   logic [7:0] model_res [8];

   adc_scan_seq #(.SETTLE_CYC(S)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .halt(halt), .rd_sel(rd_sel), .rd_data(rd_data),
      .conv_start(conv_start), .conv_chan(conv_chan), .conv_clk_en(conv_clk_en),
      .conv_done(conv_done), .conv_result(conv_result), .busy(busy)
   );

   always #5 clk = ~clk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   endtask

   // converter model plus scoreboard monitor
   initial begin
      int pend = 0;
      int cur = 0;
      for (int i = 0; i < 8; i++) model_res[i] = 0;
      forever begin
         @(negedge clk);
         conv_done = 0;
         if (pend > 0) begin
            pend--;
            if (pend == 0) begin
               conv_done = 1;
               conv_result = 8'((cur * 29) + (nres * 7) + 1);
               nres++;
               if (accept) model_res[cur] = conv_result;
            end
         end
         if (conv_start) begin
            n_starts++;
            cur = int'(conv_chan);
            pend = LAT;
            if (exp_q.size() == 0) begin
               chk(0, "R12 unexpected start", cur, -1);
            end else begin
               int e;
               e = exp_q.pop_front();
               chk(cur == e, "R3/R4 start channel", cur, e);
            end
         end
      end
   end

   task automatic write_cfg(input logic [7:0] v);
      @(negedge clk);
      cfg_we = 1;
      cfg_wdata = v;
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic expect_seq(input int lo, input int hi, input int reps);
      for (int r = 0; r < reps; r++)
         for (int c = lo; c <= hi; c++) exp_q.push_back(c);
   endtask

   task automatic wait_run_idle();
      int t = 0;
      while (!busy && t < 20000) begin @(negedge clk); t++; end
      while (busy && t < 20000) begin @(negedge clk); t++; end
      chk(t < 20000, "R12 sequence completes", t, 0);
   endtask

   task automatic chk_results(input int lo, input int hi, input string req);
      for (int c = lo; c <= hi; c++) begin
         rd_sel = 3'(c);
         #1;
         chk(rd_data == model_res[c], req, rd_data, model_res[c]);
      end
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      int b;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(cfg_rdata == 0, "R1 cfg reset", cfg_rdata, 0);
      chk(!busy && !conv_start && !conv_clk_en, "R1 outputs idle", {busy, conv_start, conv_clk_en}, 0);
      rst_n = 1;
      @(negedge clk);
      chk_results(0, 7, "R1 results zero");

      // R9 + R3 + R5: single channel 5, one-shot, requested together with power-up
      expect_seq(5, 5, 1);
      write_cfg(8'hA5);
      repeat (S - 2) @(negedge clk);
      chk(!busy && n_starts == 0, "R9 start pending during settle", n_starts, 0);
      wait_run_idle();
      chk(cfg_rdata == 8'hA4, "R5 run bit cleared", cfg_rdata, 8'hA4);
      chk_results(5, 5, "R8 result ch5");
      b = n_starts;
      repeat (20) @(negedge clk);
      chk(n_starts == b && exp_q.size() == 0, "R5 exactly one sequence", n_starts, b);

      // R4: scan 0..3 one-shot, divided clock
      expect_seq(0, 3, 1);
      write_cfg(8'h7D);
      wait_run_idle();
      chk(cfg_rdata == 8'h7C, "R5 run bit cleared after scan", cfg_rdata, 8'h7C);
      chk(exp_q.size() == 0, "R4 full scan", exp_q.size(), 0);
      chk_results(0, 3, "R8 results scan");

      // R4: field 0 scan converts only channel 0
      expect_seq(0, 0, 1);
      write_cfg(8'h0D);
      wait_run_idle();
      repeat (10) @(negedge clk);
      chk(exp_q.size() == 0 && cfg_rdata == 8'h0C, "R4 field zero", cfg_rdata, 8'h0C);
      chk_results(0, 0, "R8 result ch0");

      // R6 + R7: looping scan 0..1, stopped mid-sequence
      b = n_starts;
      expect_seq(0, 1, 3);
      expect_seq(0, 0, 1);
      write_cfg(8'h2F);
      while (n_starts < b + 3) @(negedge clk);
      chk(cfg_rdata[0] == 1'b1 && busy, "R6 run stays set while looping", cfg_rdata, 8'h2F);
      while (n_starts < b + 7) @(negedge clk);
      write_cfg(8'h2E);
      repeat (20) @(negedge clk);
      chk(!busy && n_starts == b + 7, "R7 stop after in-flight", n_starts, b + 7);
      chk(exp_q.size() == 0, "R7 no missing starts", exp_q.size(), 0);
      chk_results(0, 1, "R7 in-flight result stored");

      // R3 + R6: single channel 6 looping
      b = n_starts;
      expect_seq(6, 6, 4);
      write_cfg(8'hC7);
      while (n_starts < b + 4) @(negedge clk);
      write_cfg(8'hC6);
      repeat (20) @(negedge clk);
      chk(n_starts == b + 4 && !busy, "R6 single channel loop stop", n_starts, b + 4);
      chk_results(6, 6, "R8 result ch6");

      // R11 + R2: clock enable modes
      write_cfg(8'h14);
      chk(cfg_rdata == 8'h14, "R2 readback", cfg_rdata, 8'h14);
      begin
         bit prev;
         bit alt_ok = 1;
         @(negedge clk);
         prev = conv_clk_en;
         for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (conv_clk_en == prev) alt_ok = 0;
            prev = conv_clk_en;
         end
         chk(alt_ok, "R11 half rate enable", alt_ok, 1);
      end
      write_cfg(8'h04);
      begin
         bit on_ok = 1;
         for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (!conv_clk_en) on_ok = 0;
         end
         chk(on_ok, "R11 full rate enable", on_ok, 1);
      end

      // R10: halt during a running loop
      b = n_starts;
      expect_seq(2, 2, 10);
      write_cfg(8'h47);
      while (n_starts < b + 2) @(negedge clk);
      accept = 0;
      halt = 1;
      @(negedge clk);
      chk(cfg_rdata[2] == 1'b0, "R10 power forced off", cfg_rdata, 8'h43);
      chk(!busy && !conv_clk_en, "R10 activity stopped", {busy, conv_clk_en}, 0);
      exp_q.delete();
      repeat (10) @(negedge clk);
      chk_results(2, 2, "R10 late done ignored");
      write_cfg(8'h04);
      chk(cfg_rdata == 8'h00, "R10 write cannot power while halted", cfg_rdata, 0);
      halt = 0;
      accept = 1;

      // R9 + R4: repower then scan 0..2
      expect_seq(0, 2, 1);
      write_cfg(8'h4D);
      repeat (S - 2) @(negedge clk);
      chk(n_starts == b + 2, "R9 settle after repower", n_starts, b + 2);
      wait_run_idle();
      chk(exp_q.size() == 0 && cfg_rdata == 8'h4C, "R4 scan after repower", cfg_rdata, 8'h4C);
      chk_results(0, 2, "R8 results after repower");

      repeat (5) @(negedge clk);
      finish_run();
   end
endmodule